// File: doc/BRIEF.md
# Rational-Ratio Clock Divider with Coincidence Sync

This block divides one fast reference clock into three slower clocks: two output banks (A and C) and a feedback clock. Each clock comes from its own even divisor, picked by a small select bus. Because the divisors are chosen independently, the two banks can run at a non-binary rational frequency ratio such as 3:2 or 6:5. The feedback clock has its own select, so it can be an odd or even multiple of either bank frequency. It can also run below a bank frequency by a non-binary factor.

All three dividers share one superperiod. The superperiod length is the least common multiple of the three active divisors, and every divider restarts at its boundary. After reset the outputs therefore start phase-aligned, and they stay aligned without any further reset. An active-low sync output goes low for one fast-clock cycle, in the cycle just before each cycle in which banks A and C rise together. Downstream logic can use it to find the coincident edges. New select values are adopted only at a superperiod boundary, so no output ever produces a shortened pulse.

Top module: `rrdiv_top`

## Requirements
- R1: While rst_n is low, clk_a, clk_c and clk_fb are low and sync_n is low. In the first cycle after the first rising clock edge with rst_n high, all three clocks are high together.
- R2: A select value s below 6 gives a divisor of 2*(s+1) fast cycles, so the range is 2 to 12. Select values 6 and 7 give a divisor of 12.
- R3: An output with divisor d is high for the first d/2 fast cycles of each period and low for the remaining d/2 cycles.
- R4: The bank ratios 1:1, 2:1, 3:1, 3:2, 4:1, 4:3, 5:1, 5:2, 5:3, 6:1 and 6:5 (freq A : freq C) can all be reached, and the measured period ratio equals the selected ratio.
- R5: The superperiod length L is the least common multiple of the three active divisors. In the first cycle of every superperiod, clk_a, clk_c and clk_fb all rise together.
- R6: sync_n is low for exactly one cycle, namely the cycle before each cycle in which clk_a and clk_c rise together, and it is high in every other cycle.
- R7: The clk_fb period is set by sel_fb alone, whatever the bank selects are.
- R8: The selects are sampled only in the last cycle of a superperiod, and they take effect from the next cycle. Until then each output keeps its old divisor.
- R9: A select change that reverts before the last cycle of the current superperiod has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | 3 | Divisor select for bank A |
| sel_c | input | 3 | Divisor select for bank C |
| sel_fb | input | 3 | Divisor select for the feedback clock |
| clk_a | output | 1 | Bank A clock |
| clk_c | output | 1 | Bank C clock |
| clk_fb | output | 1 | Feedback clock |
| sync_n | output | 1 | Low one cycle before each coincident A/C rising edge |

## Verification
The bench changes selects in the middle of long superperiods. A divider that adopted them at once would then emit a clipped pulse and lose its alignment with the other outputs. It also briefly flips a select and restores it away from the boundary, which exposes any design that samples the selects outside the last cycle. Clamped select codes and the full set of listed bank ratios are measured from the gaps between rising edges. The sync output is compared every cycle, so a pulse that lands one cycle late, lasts two cycles or appears at a non-coincident edge shows up as a miscompare.

// File: rtl/rrdiv_pkg.sv
package rrdiv_pkg;

  // Even divisor picked by a select code; codes past the table clamp to the largest.
  function automatic int sel_to_div(int sel, int num_div);
    if (sel < num_div) return 2 * (sel + 1);
    return 2 * num_div;
  endfunction

  // Euclid with a fixed iteration bound so it unrolls cleanly.
  function automatic int gcd_i(int a, int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    for (int i = 0; i < 16; i++) begin
      if (y != 0) begin
        t = x % y;
        x = y;
        y = t;
      end
    end
    return x;
  endfunction

  function automatic int lcm2(int a, int b);
    if (a == 0 || b == 0) return 0;
    return (a / gcd_i(a, b)) * b;
  endfunction

endpackage

// File: rtl/rrdiv_seq.sv
module rrdiv_seq
  import rrdiv_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int NUM_DIV = 6,
  parameter int DIV_W   = 4,
  parameter int SP_W    = 12,
  parameter int NB      = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NB-1:0][SEL_W-1:0]   sel_i,
  output logic [NB-1:0][DIV_W-1:0]   div_cur_o,
  output logic [NB-1:0][DIV_W-1:0]   div_nxt_o,
  output logic                       wrap_o
);

  logic [NB-1:0][DIV_W-1:0] div_q;
  logic [NB-1:0][DIV_W-1:0] sel_div;
  logic [SP_W-1:0]          span_q;
  logic [SP_W-1:0]          span_new;
  logic [SP_W-1:0]          phase_q;
  logic                     wrap;

  for (genvar b = 0; b < NB; b++) begin : g_decode
    assign sel_div[b] = DIV_W'(sel_to_div(int'(sel_i[b]), NUM_DIV));
  end

  always_comb begin
    int acc;
    acc = 1;
    for (int b = 0; b < NB; b++) acc = lcm2(acc, int'(sel_div[b]));
    span_new = SP_W'(acc);
  end

  assign wrap      = (phase_q == span_q - SP_W'(1));
  assign wrap_o    = wrap;
  assign div_cur_o = div_q;
  assign div_nxt_o = wrap ? sel_div : div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) div_q[b] <= DIV_W'(2);
      span_q  <= SP_W'(2);
      phase_q <= SP_W'(1);
    end else if (wrap) begin
      div_q   <= sel_div;
      span_q  <= span_new;
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + SP_W'(1);
    end
  end

  // R8
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < span_q);

  // R8
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> $past(wrap));

endmodule

// File: rtl/rrdiv_bank.sv
module rrdiv_bank #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [DIV_W-1:0] div_cur_i,
  input  logic [DIV_W-1:0] div_nxt_i,
  output logic             clk_o,
  output logic             last_nxt_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] half;
  logic             clk_q;

  always_comb begin
    if (wrap_i || cnt_q == div_cur_i - DIV_W'(1)) cnt_nxt = '0;
    else                                          cnt_nxt = cnt_q + DIV_W'(1);
  end

  assign half       = div_nxt_i >> 1;
  assign last_nxt_o = (cnt_nxt == div_nxt_i - DIV_W'(1));
  assign clk_o      = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= DIV_W'(1);
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      clk_q <= (cnt_nxt < half);
    end
  end

  // Length of the current high phase, kept only for the checks below.
  logic [DIV_W-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_run_q <= '0;
    else if (clk_q) hi_run_q <= hi_run_q + DIV_W'(1);
    else            hi_run_q <= '0;
  end

  // R3
  rise_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> (cnt_q == '0));

  // R3
  high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_q) |-> (hi_run_q == (div_cur_i >> 1)));

endmodule

// File: rtl/rrdiv_top.sv
module rrdiv_top #(
  parameter int SEL_W   = 3,
  parameter int NUM_DIV = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_c,
  input  logic [SEL_W-1:0] sel_fb,
  output logic             clk_a,
  output logic             clk_c,
  output logic             clk_fb,
  output logic             sync_n
);

  localparam int NB    = 3;
  localparam int DIV_W = $clog2(2 * NUM_DIV + 1);
  localparam int SP_W  = NB * DIV_W;

  logic [NB-1:0][SEL_W-1:0] sel_pk;
  logic [NB-1:0][DIV_W-1:0] div_cur;
  logic [NB-1:0][DIV_W-1:0] div_nxt;
  logic [NB-1:0]            bank_clk;
  logic [NB-1:0]            bank_last_nxt;
  logic                     wrap;
  logic                     sync_q;

  assign sel_pk = {sel_fb, sel_c, sel_a};

  rrdiv_seq #(
    .SEL_W(SEL_W), .NUM_DIV(NUM_DIV), .DIV_W(DIV_W), .SP_W(SP_W), .NB(NB)
  ) seq_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel_pk),
    .div_cur_o(div_cur), .div_nxt_o(div_nxt), .wrap_o(wrap)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    rrdiv_bank #(.DIV_W(DIV_W)) bank_i (
      .clk_i(clk), .rst_ni(rst_n), .wrap_i(wrap),
      .div_cur_i(div_cur[b]), .div_nxt_i(div_nxt[b]),
      .clk_o(bank_clk[b]), .last_nxt_o(bank_last_nxt[b])
    );
  end

  // Low in the cycle where both banks sit on their final count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= !(bank_last_nxt[0] && bank_last_nxt[1]);
  end

  assign clk_a  = bank_clk[0];
  assign clk_c  = bank_clk[1];
  assign clk_fb = bank_clk[2];
  assign sync_n = sync_q;

  // R6
  sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |=> sync_q);

  // R6
  sync_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |=> ($rose(clk_a) && $rose(clk_c)));

  // R6
  coincide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_a) && $rose(clk_c)) |-> $past(!sync_q));

  // R5
  boundary_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ($rose(clk_a) && $rose(clk_c) && $rose(clk_fb)));

endmodule

// File: tb/rrdiv_top_tb.sv
module rrdiv_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel_a, sel_c, sel_fb;
  logic       clk_a, clk_c, clk_fb, sync_n;

  always #2 clk = ~clk;

  rrdiv_top dut_i (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_c(sel_c), .sel_fb(sel_fb),
    .clk_a(clk_a), .clk_c(clk_c), .clk_fb(clk_fb), .sync_n(sync_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  int t, span, da, dc, dfb;
  int cyc = 0;
  int ra = 0, rc = 0, rf = 0;
  int per_a = 0, per_c = 0, per_f = 0;
  logic pa = 1'b0, pc = 1'b0, pf = 1'b0, psync = 1'b1;
  bit   watch_r9 = 0;

  function automatic int div_of(logic [2:0] s);
    if (s >= 3'd6) return 12;
    return (int'(s) + 1) * 2;
  endfunction

  // Smallest value divisible by all three, found by search.
  function automatic int lcm_b(int a, int b, int c);
    int m;
    m = a;
    while ((m % a) != 0 || (m % b) != 0 || (m % c) != 0) m++;
    return m;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_update();
    if (!rst_n) begin
      da = 2; dc = 2; dfb = 2; span = 2; t = 1;
    end else if (t == span - 1) begin
      da = div_of(sel_a); dc = div_of(sel_c); dfb = div_of(sel_fb);
      span = lcm_b(da, dc, dfb);
      t = 0;
    end else begin
      t++;
    end
  endtask

  task automatic compare();
    bit pend;
    bit ea, ec, ef, es;
    pend = (div_of(sel_a) != da) || (div_of(sel_c) != dc) || (div_of(sel_fb) != dfb);
    ea = (t % da) < (da / 2);
    ec = (t % dc) < (dc / 2);
    ef = (t % dfb) < (dfb / 2);
    es = !(((t + 1) % da == 0) && ((t + 1) % dc == 0));
    check(clk_a == ea, pend ? "R8" : "R3", "clk_a", clk_a, ea);
    check(clk_c == ec, pend ? "R8" : "R3", "clk_c", clk_c, ec);
    check(clk_fb == ef, pend ? "R8" : "R7", "clk_fb", clk_fb, ef);
    check(sync_n == es, "R6", "sync_n", sync_n, es);
    if (rst_n && t == 0)   // R5: all three rise at the boundary
      check(clk_a && clk_c && clk_fb, "R5", "boundary rise a&c&fb", {clk_a, clk_c, clk_fb}, 7);
    if (rst_n && !psync)   // R6: low sync followed by a coincident rise
      check(clk_a && !pa && clk_c && !pc, "R6", "rise after sync", {clk_a, clk_c}, 3);
    if (clk_a && !pa) begin
      per_a = cyc - ra; ra = cyc;
      if (watch_r9) check(per_a == 10, "R9", "clk_a period after transient", per_a, 10);
    end
    if (clk_c && !pc) begin per_c = cyc - rc; rc = cyc; end
    if (clk_fb && !pf) begin per_f = cyc - rf; rf = cyc; end
    pa = clk_a; pc = clk_c; pf = clk_fb; psync = sync_n;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run(3);
    // R1: reset levels
    check(!clk_a && !clk_c && !clk_fb && !sync_n, "R1", "reset levels",
          {clk_a, clk_c, clk_fb, sync_n}, 0);
    rst_n = 1'b1;
    step();
    // R1: first edge after release is aligned
    check(clk_a && clk_c && clk_fb, "R1", "first edge aligned", {clk_a, clk_c, clk_fb}, 7);
  endtask

  int ra_tab [11] = '{1, 2, 3, 3, 4, 4, 5, 5, 5, 6, 6};
  int rc_tab [11] = '{1, 1, 1, 2, 1, 3, 1, 2, 3, 1, 5};
  int dva    [11] = '{2, 2, 2, 4, 2, 6, 2, 4, 6, 2, 10};
  int dvc    [11] = '{2, 4, 6, 6, 8, 8, 10, 10, 10, 12, 12};

  initial begin
    void'($urandom(32'd2718));
    sel_a = 3'd1; sel_c = 3'd2; sel_fb = 3'd0;
    do_reset();

    // R4 and R7: every listed ratio, with the feedback select varied.
    for (int k = 0; k < 11; k++) begin
      sel_a  = 3'(dva[k] / 2 - 1);
      sel_c  = 3'(dvc[k] / 2 - 1);
      sel_fb = 3'(k % 6);
      run(400);
      check(per_c * rc_tab[k] == per_a * ra_tab[k], "R4", "period ratio c*rc vs a*ra",
            per_c * rc_tab[k], per_a * ra_tab[k]);
      check(per_a == dva[k], "R4", "clk_a period", per_a, dva[k]);
      check(per_fb_ok(k), "R7", "clk_fb period", per_f, 2 * (k % 6 + 1));
    end

    // R2: clamped select codes.
    sel_a = 3'd7; sel_c = 3'd6; sel_fb = 3'd7;
    run(200);
    check(per_a == 12, "R2", "clk_a period sel 7", per_a, 12);
    check(per_c == 12, "R2", "clk_c period sel 6", per_c, 12);

    // R8: change in mid superperiod of a long span (10,12,8 -> 120).
    sel_a = 3'd4; sel_c = 3'd5; sel_fb = 3'd3;
    run(300);
    while (t != 3) step();
    sel_a = 3'd2;
    run(250);
    check(per_a == 6, "R8", "clk_a period after boundary", per_a, 6);

    // R9: transient select flip well inside the superperiod.
    sel_a = 3'd4;
    run(300);
    while (t != 5) step();
    sel_a = 3'd0; run(3); sel_a = 3'd4;
    watch_r9 = 1;
    run(110);
    watch_r9 = 0;

    // Random select changes at random times, including the clamp codes.
    for (int k = 0; k < 40; k++) begin
      sel_a  = 3'($urandom_range(7, 0));
      sel_c  = 3'($urandom_range(7, 0));
      sel_fb = 3'($urandom_range(7, 0));
      run($urandom_range(300, 1));
    end

    // R1: a second reset in mid run.
    do_reset();
    run(100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic bit per_fb_ok(int k);
    return per_f == 2 * (k % 6 + 1);
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule